// File: doc/BRIEF.md
# Transmit Timestamp Capture Unit

This block records the instant at which a transmit frame marked for time stamping leaves the port. The MAC raises a one-cycle request when such a frame is accepted for stamping. The unit then waits for the departure strobe, and at that strobe it latches the current hardware clock value and the frame's sequence identifier into registers that the host can read. A capture-ready flag drives a maskable interrupt line.

Only one stamp can be outstanding. A request that arrives while a stamp is pending is refused and counted as skipped. The pending stamp is released in one of three ways: the host reads the high-seconds word, the host writes one to clear the ready flag, or a programmable cycle timeout expires. Three event counters record accepted requests, skipped requests and expired stamps.

Top module: `tx_tstamp_capture`

## Requirements
- R1: After reset, every readable register reads zero, except the timeout limit at 0x24, which reads the parameter TMO_INIT. `irq` is low.
- R2: A `ts_req` pulse while nothing is pending is accepted. The unit becomes pending in the waiting phase, and the request counter at 0x10 increments.
- R3: A `depart` strobe in the waiting phase latches the following values:
  - the 30-bit nanoseconds, read at 0x04 with bits 31:30 zero;
  - seconds bits 31:0, read at 0x08;
  - seconds bits 47:32, read at 0x0C with bits 31:16 zero;
  - `depart_seq`, read at 0x00.
  
  The same strobe sets bit 0 of the status register at 0x1C.
- R4: A `ts_req` while a stamp is pending is refused and leaves the request counter unchanged. The skipped counter at 0x14 increments. This includes a request at the same edge that releases the stamp.
- R5: A `depart` strobe outside the waiting phase is ignored. The last captured values, including the sequence identifier, stay readable while nothing is pending.
- R6: A read of 0x0C while the capture is ready releases the pending state and clears status bit 0.
- R7: Writing a 1 to bit 0 of 0x1C releases the pending state and clears status bit 0.
- R8: `irq` equals status bit 0 AND bit 0 of the enable register at 0x20, with no added cycle of lag.
- R9: A stamp still pending at the Nth clock edge after acceptance is released at that edge. N is the value of the limit register at 0x24, with a minimum of 1. The release clears status bit 0 and increments the timeout counter at 0x18.
- R10: If the timeout and a departure strobe fall on the same edge, the timeout wins and nothing is captured.
- R11: `rd_data` is registered and reflects the state just before the edge that samples `rd_en`. Status bit 1 reads 1 while a stamp is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_req | input | 1 | Frame accepted for stamping (one-cycle pulse) |
| depart | input | 1 | Flagged frame leaves the port |
| depart_seq | input | SEQ_W | Sequence identifier of the departing frame |
| now_ns | input | NS_W | Clock nanoseconds |
| now_sec | input | SEC_W | Clock seconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Capture-ready interrupt |

## Verification
Two collisions can occur in the same cycle.

- **Timeout and departure.** The bench sets the limit to 5, issues a request and places the departure strobe exactly on the fifth edge. It then expects status 0, an unchanged sequence register and an incremented timeout count. A second run places the strobe one edge earlier and expects a capture.
- **Request and release.** A request is driven in the same cycle as the high-seconds read that frees the unit. The bench expects that request to be counted as skipped.

// File: rtl/tts_pkg.sv
package tts_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_WAIT  = 2'd1,
    TS_READY = 2'd2
  } ts_state_e;

  // byte offsets of the register map
  localparam int OFS_SEQ  = 0;
  localparam int OFS_NS   = 4;
  localparam int OFS_SECL = 8;
  localparam int OFS_SECH = 12;
  localparam int OFS_REQ  = 16;
  localparam int OFS_SKIP = 20;
  localparam int OFS_TMO  = 24;
  localparam int OFS_ISR  = 28;
  localparam int OFS_IEN  = 32;
  localparam int OFS_TLIM = 36;

  // event counter indices
  localparam int NUM_EVT  = 3;
  localparam int EVT_REQ  = 0;
  localparam int EVT_SKIP = 1;
  localparam int EVT_TMO  = 2;
endpackage

// File: rtl/tts_ctrl.sv
module tts_ctrl
  import tts_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ts_req,
  input  logic             depart,
  input  logic             release_req,
  input  logic [TMO_W-1:0] tmo_limit,
  output ts_state_e        state,
  output logic             accept,
  output logic             skip,
  output logic             expire,
  output logic             capture
);
  logic [TMO_W-1:0] timer;
  logic             busy;

  always_comb begin
    busy    = (state != TS_IDLE);
    accept  = ts_req && !busy;
    skip    = ts_req && busy;
    expire  = busy && (timer >= tmo_limit);
    capture = (state == TS_WAIT) && depart && !expire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TS_IDLE;
      timer <= '0;
    end else begin
      if (expire) begin
        state <= TS_IDLE;
      end else begin
        case (state)
          TS_IDLE:  if (ts_req)      state <= TS_WAIT;
          TS_WAIT:  if (depart)      state <= TS_READY;
          TS_READY: if (release_req) state <= TS_IDLE;
          default:                   state <= TS_IDLE;
        endcase
      end
      // timer counts clock edges since acceptance, starting at one
      if (accept)
        timer <= TMO_W'(1);
      else if (busy && (timer != '1))
        timer <= timer + 1'b1;
    end
  end
endmodule

// File: rtl/tts_evcnt.sv
module tts_evcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/tts_latch.sv
module tts_latch #(
  parameter int NS_W  = 30,
  parameter int SEC_W = 48,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [NS_W-1:0]  ns_in,
  input  logic [SEC_W-1:0] sec_in,
  input  logic [SEQ_W-1:0] seq_in,
  output logic [NS_W-1:0]  cap_ns,
  output logic [SEC_W-1:0] cap_sec,
  output logic [SEQ_W-1:0] cap_seq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_ns  <= '0;
      cap_sec <= '0;
      cap_seq <= '0;
    end else if (capture) begin
      cap_ns  <= ns_in;
      cap_sec <= sec_in;
      cap_seq <= seq_in;
    end
  end
endmodule

// File: rtl/tts_regs.sv
module tts_regs
  import tts_pkg::*;
#(
  parameter int              ADDR_W   = 6,
  parameter int              NS_W     = 30,
  parameter int              SEC_W    = 48,
  parameter int              SEQ_W    = 16,
  parameter int              CNT_W    = 32,
  parameter int              TMO_W    = 32,
  parameter logic [TMO_W-1:0] TMO_INIT = TMO_W'(125_000_000)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [31:0]                   wr_data,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [NS_W-1:0]               cap_ns,
  input  logic [SEC_W-1:0]              cap_sec,
  input  logic [SEQ_W-1:0]              cap_seq,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] counts,
  input  ts_state_e                     state,
  input  logic                          capture,
  input  logic                          expire,
  output logic                          release_req,
  output logic [TMO_W-1:0]              tmo_limit,
  output logic                          int_en,
  output logic                          int_src,
  output logic [31:0]                   rd_data,
  output logic                          irq
);
  localparam int SECH_W = SEC_W - 32;

  logic        int_en_d, int_src_d;
  logic [31:0] rd_word;

  always_comb begin
    release_req = (rd_en && (rd_addr == ADDR_W'(OFS_SECH))) ||
                  (wr_en && (wr_addr == ADDR_W'(OFS_ISR)) && wr_data[0]);
    int_en_d = int_en;
    if (wr_en && (wr_addr == ADDR_W'(OFS_IEN)))
      int_en_d = wr_data[0];
    int_src_d = int_src;
    if (capture)
      int_src_d = 1'b1;
    else if (expire || release_req)
      int_src_d = 1'b0;
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADDR_W'(OFS_SEQ):  rd_word[SEQ_W-1:0]  = cap_seq;
      ADDR_W'(OFS_NS):   rd_word[NS_W-1:0]   = cap_ns;
      ADDR_W'(OFS_SECL): rd_word             = cap_sec[31:0];
      ADDR_W'(OFS_SECH): rd_word[SECH_W-1:0] = cap_sec[SEC_W-1:32];
      ADDR_W'(OFS_REQ):  rd_word[CNT_W-1:0]  = counts[EVT_REQ];
      ADDR_W'(OFS_SKIP): rd_word[CNT_W-1:0]  = counts[EVT_SKIP];
      ADDR_W'(OFS_TMO):  rd_word[CNT_W-1:0]  = counts[EVT_TMO];
      ADDR_W'(OFS_ISR):  rd_word[1:0]        = {state != TS_IDLE, int_src};
      ADDR_W'(OFS_IEN):  rd_word[0]          = int_en;
      ADDR_W'(OFS_TLIM): rd_word[TMO_W-1:0]  = tmo_limit;
      default:           rd_word             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en    <= 1'b0;
      int_src   <= 1'b0;
      irq       <= 1'b0;
      tmo_limit <= TMO_INIT;
      rd_data   <= '0;
    end else begin
      int_en  <= int_en_d;
      int_src <= int_src_d;
      irq     <= int_src_d && int_en_d;
      if (wr_en && (wr_addr == ADDR_W'(OFS_TLIM)))
        tmo_limit <= wr_data[TMO_W-1:0];
      if (rd_en)
        rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/tx_tstamp_capture.sv
module tx_tstamp_capture
  import tts_pkg::*;
#(
  parameter int              ADDR_W   = 6,
  parameter int              NS_W     = 30,
  parameter int              SEC_W    = 48,
  parameter int              SEQ_W    = 16,
  parameter int              CNT_W    = 32,
  parameter int              TMO_W    = 32,
  parameter logic [TMO_W-1:0] TMO_INIT = TMO_W'(125_000_000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ts_req,
  input  logic              depart,
  input  logic [SEQ_W-1:0]  depart_seq,
  input  logic [NS_W-1:0]   now_ns,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  ts_state_e                     st;
  logic                          accept, skip, expire, capture;
  logic                          release_req, int_en, int_src;
  logic [TMO_W-1:0]              tmo_limit;
  logic [NS_W-1:0]               cap_ns;
  logic [SEC_W-1:0]              cap_sec;
  logic [SEQ_W-1:0]              cap_seq;
  logic [NUM_EVT-1:0]            evt;
  logic [NUM_EVT-1:0][CNT_W-1:0] counts;

  tts_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst(rst), .ts_req(ts_req), .depart(depart),
    .release_req(release_req), .tmo_limit(tmo_limit), .state(st),
    .accept(accept), .skip(skip), .expire(expire), .capture(capture)
  );

  tts_latch #(.NS_W(NS_W), .SEC_W(SEC_W), .SEQ_W(SEQ_W)) u_latch (
    .clk(clk), .rst(rst), .capture(capture), .ns_in(now_ns),
    .sec_in(now_sec), .seq_in(depart_seq), .cap_ns(cap_ns),
    .cap_sec(cap_sec), .cap_seq(cap_seq)
  );

  always_comb begin
    evt           = '0;
    evt[EVT_REQ]  = accept;
    evt[EVT_SKIP] = skip;
    evt[EVT_TMO]  = expire;
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
    tts_evcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(evt[g]), .count(counts[g])
    );
  end

  tts_regs #(
    .ADDR_W(ADDR_W), .NS_W(NS_W), .SEC_W(SEC_W), .SEQ_W(SEQ_W),
    .CNT_W(CNT_W), .TMO_W(TMO_W), .TMO_INIT(TMO_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .cap_ns(cap_ns), .cap_sec(cap_sec), .cap_seq(cap_seq),
    .counts(counts), .state(st), .capture(capture), .expire(expire),
    .release_req(release_req), .tmo_limit(tmo_limit), .int_en(int_en),
    .int_src(int_src), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/tts_checker.sv
module tts_checker
  import tts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ts_req,
  input logic              depart,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              irq,
  input ts_state_e         state,
  input logic              int_src,
  input logic              int_en,
  input logic              expire,
  input logic [CNT_W-1:0]  req_cnt
);
  a_r3_src_tracks_ready: assert property (@(posedge clk) disable iff (rst)
    int_src == (state == TS_READY));

  a_r2_accept_counts: assert property (@(posedge clk) disable iff (rst)
    (ts_req && state == TS_IDLE) |=>
      (state == TS_WAIT && (req_cnt - $past(req_cnt)) == CNT_W'(1)));

  a_r4_skip_no_count: assert property (@(posedge clk) disable iff (rst)
    (ts_req && state != TS_IDLE) |=> (req_cnt == $past(req_cnt)));

  a_r6_read_release: assert property (@(posedge clk) disable iff (rst)
    (state == TS_READY && rd_en && rd_addr == ADDR_W'(OFS_SECH) && !expire)
      |=> (state == TS_IDLE));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> (int_src && int_en));

  a_r9_expire_frees: assert property (@(posedge clk) disable iff (rst)
    expire |=> (state == TS_IDLE && !int_src));

  a_r10_timeout_beats_depart: assert property (@(posedge clk) disable iff (rst)
    (expire && depart) |=> !int_src);
endmodule

bind tx_tstamp_capture tts_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ts_req(ts_req), .depart(depart), .rd_en(rd_en),
  .rd_addr(rd_addr), .irq(irq), .state(st), .int_src(int_src),
  .int_en(int_en), .expire(expire), .req_cnt(counts[0])
);

// File: tb/tx_tstamp_capture_tb.sv
module tx_tstamp_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TMO_INIT = 32'd125_000_000;
  localparam int NVEC = 5;
  // {seq[15:0], ns[29:0], sec[47:0]}
  localparam logic [93:0] VEC [NVEC] = '{
    {16'h0001, 30'h0000_0000, 48'h0000_0000_0000},
    {16'hABCD, 30'h3FFF_FFFF, 48'hFFFF_FFFF_FFFF},
    {16'h1234, 30'd999_999_999, 48'h0001_0000_0000},
    {16'hFFFF, 30'h1555_5555, 48'h8000_2AAA_5555},
    {16'h0042, 30'h2AAA_AAAA, 48'h0000_FFFF_FFFF}
  };

  logic        clk = 0, rst = 1;
  logic        ts_req = 0, depart = 0, wr_en = 0, rd_en = 0;
  logic [15:0] depart_seq = '0;
  logic [29:0] now_ns = '0;
  logic [47:0] now_sec = '0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, rv;
  logic        irq;
  int          n_tests = 0, n_fail = 0;

  tx_tstamp_capture #(.TMO_INIT(TMO_INIT)) u_dut (
    .clk(clk), .rst(rst), .ts_req(ts_req), .depart(depart),
    .depart_seq(depart_seq), .now_ns(now_ns), .now_sec(now_sec),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en = 1; rd_addr = a; step(); d = rd_data; rd_en = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic req_pulse();
    ts_req = 1; step(); ts_req = 0;
  endtask

  task automatic dep(input logic [15:0] s, input logic [29:0] n, input logic [47:0] c);
    depart_seq = s; now_ns = n; now_sec = c; depart = 1; step(); depart = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1..: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(6'h1C, rv); check("R1 isr", rv, 0);
    rd(6'h00, rv); check("R1 seq", rv, 0);
    rd(6'h04, rv); check("R1 ns", rv, 0);
    rd(6'h10, rv); check("R1 req cnt", rv, 0);
    rd(6'h14, rv); check("R1 skip cnt", rv, 0);
    rd(6'h18, rv); check("R1 tmo cnt", rv, 0);
    rd(6'h20, rv); check("R1 ien", rv, 0);
    rd(6'h24, rv); check("R1 tlim", rv, TMO_INIT);

    wr(6'h20, 32'h1);
    // vector table: R2, R3, R6, R8, R11, R5
    for (int i = 0; i < NVEC; i++) begin
      req_pulse();
      rd(6'h1C, rv); check("R2 pending wait", rv, 32'h2);
      dep(VEC[i][93:78], VEC[i][77:48], VEC[i][47:0]);
      check("R8 irq on capture", {31'b0, irq}, 32'h1);
      rd(6'h1C, rv); check("R11 isr ready", rv, 32'h3);
      rd(6'h00, rv); check("R3 seq", rv, {16'h0, VEC[i][93:78]});
      rd(6'h04, rv); check("R3 ns", rv, {2'b0, VEC[i][77:48]});
      rd(6'h08, rv); check("R3 sec lo", rv, VEC[i][31:0]);
      rd(6'h0C, rv); check("R3 sec hi", rv, {16'h0, VEC[i][47:32]});
      check("R6 irq cleared", {31'b0, irq}, 32'h0);
      rd(6'h1C, rv); check("R6 released", rv, 32'h0);
      dep(16'h5A5A, 30'h1, 48'h2);
      rd(6'h00, rv); check("R5 stale depart ignored", rv, {16'h0, VEC[i][93:78]});
      rd(6'h10, rv); check("R2 req cnt", rv, 32'(i + 1));
    end

    // R4 skip while pending
    req_pulse();
    req_pulse();
    dep(16'h0007, 30'h7, 48'h7);
    req_pulse();
    rd(6'h14, rv); check("R4 skip cnt", rv, 32'd2);
    rd(6'h10, rv); check("R4 req cnt held", rv, 32'd6);
    // R8 mask
    wr(6'h20, 32'h0);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(6'h1C, rv); check("R8 isr still set", rv, 32'h3);
    // R7 write-one-to-clear
    wr(6'h1C, 32'h1);
    rd(6'h1C, rv); check("R7 w1c release", rv, 32'h0);
    wr(6'h20, 32'h1);

    // R4 request on the releasing edge
    req_pulse();
    dep(16'h0008, 30'h8, 48'h8);
    rd_en = 1; rd_addr = 6'h0C; ts_req = 1; step(); rd_en = 0; ts_req = 0;
    rd(6'h1C, rv); check("R4 release edge state", rv, 32'h0);
    rd(6'h14, rv); check("R4 skip on release edge", rv, 32'd3);

    // R9 timeout boundary, limit 5
    wr(6'h24, 32'd5);
    req_pulse();
    repeat (3) step();
    rd(6'h1C, rv); check("R9 pending edge4", rv, 32'h2);
    rd(6'h1C, rv); check("R9 pending edge5", rv, 32'h2);
    rd(6'h1C, rv); check("R9 released", rv, 32'h0);
    rd(6'h18, rv); check("R9 tmo cnt", rv, 32'd1);

    // R10 departure on the expiry edge
    req_pulse();
    repeat (4) step();
    dep(16'h0099, 30'h9, 48'h9);
    check("R10 no irq", {31'b0, irq}, 32'h0);
    rd(6'h1C, rv); check("R10 isr", rv, 32'h0);
    rd(6'h00, rv); check("R10 seq unchanged", rv, 32'h0008);
    rd(6'h18, rv); check("R10 tmo cnt", rv, 32'd2);

    // R9 departure one edge before expiry captures, then ready expires
    req_pulse();
    repeat (3) step();
    dep(16'h0077, 30'h77, 48'h77);
    check("R9 irq early capture", {31'b0, irq}, 32'h1);
    rd(6'h00, rv); check("R9 seq captured", rv, 32'h0077);
    rd(6'h1C, rv); check("R9 ready expired", rv, 32'h0);
    rd(6'h18, rv); check("R9 tmo cnt ready", rv, 32'd3);
    rd(6'h10, rv); check("R2 req cnt final", rv, 32'd10);

    finish_run();
  end
endmodule